// File: doc/BRIEF.md
# Display Interrupt Status Controller

This block gathers single-cycle event pulses from a display engine into sticky status bits and turns them into one interrupt line. The five events are sync lost, FIFO underflow, palette load done, end of frame 0 and end of frame 1. Software reads the status through a small register port. It can read it raw, or filtered by an enable register. The enable register is changed through two separate addresses: one only sets bits and the other only clears them. Status bits are cleared by writing ones to the filtered-status address.

The interrupt line is gated by an arm flag. While the block is armed, the line is high whenever any enabled status bit is set. In the cycle after the line has been high, the flag drops, so each arming gives a single one-cycle pulse. A write of any value to the end-of-interrupt address arms the block again. Reads are combinational from the address. Only the bit positions and offsets that software decodes are fixed; all other register bits read as zero.

Top module: `disp_irq_status`

## Requirements
- R1: After reset the status and enable registers are zero, every address reads zero, the block is armed and `irq` is low.
- R2: An event pulse sets its status bit at the next clock edge, and the bit stays set until it is cleared. The bit positions are: sync lost 2, FIFO underflow 5, palette load done 6, end of frame 0 bit 8, end of frame 1 bit 9. Raw status is read at offset 0x58.
- R3: A read at offset 0x5C returns the raw status ANDed with the enable register.
- R4: Writing to offset 0x60 sets each enable bit whose write-data bit is 1 and leaves the other enable bits unchanged. The enable register reads back at offset 0x60 and at offset 0x64.
- R5: Writing to offset 0x64 clears each enable bit whose write-data bit is 1 and leaves the other enable bits unchanged.
- R6: Writing to offset 0x5C clears each status bit whose write-data bit is 1 and leaves the other status bits unchanged. A write to offset 0x58 changes no status bit.
- R7: If an event pulse arrives in the same cycle as a clear of its status bit, the bit stays set.
- R8: `irq` is high exactly when the block is armed and at least one enabled status bit is set. This is combinational from the registered state.
- R9: After a cycle with `irq` high, the block is disarmed and `irq` stays low until a write of any data to offset 0x68. From the next cycle after that write, `irq` follows R8 again.
- R10: Enable and status bits outside positions 2, 5, 6, 8 and 9 cannot be set and always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_sync_lost | input | 1 | Sync-lost event pulse |
| ev_underflow | input | 1 | FIFO underflow event pulse |
| ev_pal_done | input | 1 | Palette load done event pulse |
| ev_frame0 | input | 1 | End of frame 0 event pulse |
| ev_frame1 | input | 1 | End of frame 1 event pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the block with its default parameters: an 8-bit offset, which reaches all five register offsets and one unused offset, and a 32-bit data word, so writes of all ones also hit the bit positions that are not implemented. With these values the bench can drive the event/clear collision, an end-of-interrupt write while enabled status is still pending, and the enable of an already-set status bit while armed. It can also check that the arm flag suppresses a second pulse when another event arrives.

// File: rtl/disp_irq_status.sv
module disp_irq_status #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_sync_lost,
  input  logic              ev_underflow,
  input  logic              ev_pal_done,
  input  logic              ev_frame0,
  input  logic              ev_frame1,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFS_RAW = ADDR_W'(8'h58);
  localparam logic [ADDR_W-1:0] OFS_MSK = ADDR_W'(8'h5C);
  localparam logic [ADDR_W-1:0] OFS_SET = ADDR_W'(8'h60);
  localparam logic [ADDR_W-1:0] OFS_CLR = ADDR_W'(8'h64);
  localparam logic [ADDR_W-1:0] OFS_EOI = ADDR_W'(8'h68);
  localparam int BIT_SYNC = 2;
  localparam int BIT_UFL  = 5;
  localparam int BIT_PAL  = 6;
  localparam int BIT_FR0  = 8;
  localparam int BIT_FR1  = 9;
  localparam logic [DATA_W-1:0] IMPL =
    (DATA_W'(1) << BIT_SYNC) | (DATA_W'(1) << BIT_UFL) | (DATA_W'(1) << BIT_PAL) |
    (DATA_W'(1) << BIT_FR0)  | (DATA_W'(1) << BIT_FR1);

  logic [DATA_W-1:0] raw_q, en_q, ev_vec, masked;
  logic              armed_q;
  logic              hit_msk, hit_set, hit_clr, hit_eoi;

  always_comb begin
    ev_vec           = '0;
    ev_vec[BIT_SYNC] = ev_sync_lost;
    ev_vec[BIT_UFL]  = ev_underflow;
    ev_vec[BIT_PAL]  = ev_pal_done;
    ev_vec[BIT_FR0]  = ev_frame0;
    ev_vec[BIT_FR1]  = ev_frame1;
  end

  assign hit_msk = reg_wr && (reg_addr == OFS_MSK);
  assign hit_set = reg_wr && (reg_addr == OFS_SET);
  assign hit_clr = reg_wr && (reg_addr == OFS_CLR);
  assign hit_eoi = reg_wr && (reg_addr == OFS_EOI);

  assign masked = raw_q & en_q;
  assign irq    = armed_q && (|masked);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q   <= '0;
      en_q    <= '0;
      armed_q <= 1'b1;
    end else begin
      raw_q <= ((raw_q & ~(hit_msk ? reg_wdata : '0)) | ev_vec) & IMPL;
      en_q  <= ((en_q | (hit_set ? reg_wdata : '0)) & ~(hit_clr ? reg_wdata : '0)) & IMPL;
      if (hit_eoi)  armed_q <= 1'b1;
      else if (irq) armed_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_RAW:          reg_rdata = raw_q;
      OFS_MSK:          reg_rdata = masked;
      OFS_SET, OFS_CLR: reg_rdata = en_q;
      default:          reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/disp_irq_status_chk.sv
module disp_irq_status_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_frame0,
  input logic              ev_frame1,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] raw_q,
  input logic [DATA_W-1:0] en_q,
  input logic              armed_q,
  input logic              irq
);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(8'h64);
  localparam logic [ADDR_W-1:0] A_EOI = ADDR_W'(8'h68);
  localparam logic [DATA_W-1:0] KEEP  = DATA_W'(32'h364);

  assert_frame0_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame0 |=> raw_q[8]);

  assert_event_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame1 |=> raw_q[9]);

  assert_clear_drops_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CLR) |=> ((en_q & $past(reg_wdata)) == '0));

  assert_irq_needs_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (armed_q && ((raw_q & en_q) != '0)));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(reg_wr && reg_addr == A_EOI)) |=> !irq);

  assert_no_stray_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_q & ~KEEP) == '0) && ((en_q & ~KEEP) == '0));
endmodule

bind disp_irq_status disp_irq_status_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_frame0(ev_frame0), .ev_frame1(ev_frame1),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .raw_q(raw_q), .en_q(en_q), .armed_q(armed_q), .irq(irq)
);

// File: tb/test_disp_irq_status.sv
module test_disp_irq_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_sync_lost = 0, ev_underflow = 0, ev_pal_done = 0, ev_frame0 = 0, ev_frame1 = 0;
  logic        reg_wr = 0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  int          n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  disp_irq_status i_disp_irq_status (
    .clk(clk), .rst_n(rst_n), .ev_sync_lost(ev_sync_lost), .ev_underflow(ev_underflow),
    .ev_pal_done(ev_pal_done), .ev_frame0(ev_frame0), .ev_frame1(ev_frame1),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 0; reg_addr = 8'h00; reg_wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a; #1;
    chk(req, reg_rdata, exp);
    reg_addr = 8'h00;
  endtask

  task automatic pulse(input logic s, u, p, f0, f1);
    @(negedge clk);
    ev_sync_lost = s; ev_underflow = u; ev_pal_done = p; ev_frame0 = f0; ev_frame1 = f1;
    step();
    ev_sync_lost = 0; ev_underflow = 0; ev_pal_done = 0; ev_frame0 = 0; ev_frame1 = 0;
  endtask

  task automatic t_reset();
    rd_chk("R1 raw", 8'h58, 0);
    rd_chk("R1 masked", 8'h5C, 0);
    rd_chk("R1 enable", 8'h60, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_events();
    pulse(0, 0, 0, 1, 0);
    rd_chk("R2 frame0 bit8", 8'h58, 32'h100);
    rd_chk("R3 masked with no enable", 8'h5C, 0);
    chk("R8 irq low while disabled", irq, 0);
    pulse(1, 1, 1, 0, 1);
    rd_chk("R2 all events", 8'h58, 32'h364);
    wr(8'h58, 32'hFFFF_FFFF);
    rd_chk("R6 raw address write ignored", 8'h58, 32'h364);
  endtask

  task automatic t_enable_and_pulse();
    wr(8'h60, 32'h100);
    chk("R8 irq on enable while armed", irq, 1);
    rd_chk("R3 masked", 8'h5C, 32'h100);
    step();
    chk("R9 irq drops after one cycle", irq, 0);
    wr(8'h60, 32'h200);
    rd_chk("R4 set keeps old bits", 8'h64, 32'h300);
    chk("R9 disarmed stays low", irq, 0);
    wr(8'h60, 32'hFFFF_FFFF);
    rd_chk("R10 unimplemented enable bits", 8'h60, 32'h364);
    wr(8'h64, 32'h064);
    rd_chk("R5 clear selected bits", 8'h60, 32'h300);
  endtask

  task automatic t_w1c_and_eoi();
    wr(8'h5C, 32'h100);
    rd_chk("R6 w1c bit8 only", 8'h58, 32'h264);
    chk("R9 still disarmed", irq, 0);
    wr(8'h68, 32'h0);
    chk("R9 eoi re-arms with pending bit9", irq, 1);
    step();
    chk("R9 pulse ends", irq, 0);
  endtask

  task automatic t_collision();
    @(negedge clk);
    ev_frame1 = 1; reg_wr = 1; reg_addr = 8'h5C; reg_wdata = 32'h200;
    step();
    ev_frame1 = 0; reg_wr = 0; reg_addr = 8'h00; reg_wdata = '0;
    rd_chk("R7 event wins over clear", 8'h58, 32'h264);
  endtask

  task automatic t_rearm_late();
    wr(8'h5C, 32'hFFFF_FFFF);
    rd_chk("R6 clear all", 8'h58, 0);
    rd_chk("R10 unused offset reads zero", 8'h6C, 0);
    wr(8'h68, 32'h1234);
    chk("R8 armed but nothing pending", irq, 0);
    pulse(0, 1, 0, 0, 0);
    chk("R8 underflow not enabled", irq, 0);
    wr(8'h60, 32'h020);
    chk("R8 irq when enabling pending bit", irq, 1);
    step();
    chk("R9 low after pulse", irq, 0);
    pulse(0, 0, 0, 0, 1);
    chk("R9 new event while disarmed", irq, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) step();
        rst_n = 1;
        t_reset();
        t_events();
        t_enable_and_pulse();
        t_w1c_and_eoi();
        t_collision();
        t_rearm_late();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule